// File: doc/BRIEF.md
# Single-Step and Branch Trace Interrupt Entry

This block watches the completion stream of a 32-bit processor core and performs the entry sequence for the trace interrupt. When the processor state word enables per-instruction stepping or per-branch tracing, each qualifying completion causes an interrupt entry. The entry has four parts. The return address and a filtered copy of the state word go into two save registers. A rewritten state word is handed back to the core. A one-clock redirect pulse carrying the trace vector address goes to the fetch unit.

Bit positions in this document count from the least significant bit, bit 0 being the LSB. State-word fields use these positions: LE 0, RI 1, IP 6, BE 9, SE 10, ME 12, ILE 16. A monitor or debugger reads and writes the two save registers through a small register port. `rp_sel` = 0 selects the return-address register, and `rp_sel` = 1 selects the saved-state register.

Top module: `trace_entry_unit`

## Requirements
- R1: A completion (`cmp_valid`=1) with SE=1 and `cmp_is_rfi`=0 causes a trace entry. A completion flagged rfi with SE=1 and BE=0 causes none.
- R2: A completion flagged branch with BE=1 causes a trace entry, even when SE=0. A non-branch completion with BE=1 and SE=0 causes none.
- R3: No entry happens when `cmp_faulted`=1 or `other_irq`=1 in the completion cycle. In that case, redirect stays low and both save registers keep their values.
- R4: On entry, the return-address register is loaded with `cmp_next_addr`.
- R5: On entry, saved-state bits 31..16 become 0. Bits 15..2 and bit 0 are copied from the state word.
- R6: Saved-state bit 1 is sticky on entry. Its new value is its old value AND state-word bit RI. A one in RI never sets it.
- R7: The new state word keeps IP and ME, sets LE to ILE, and is 0 in every other bit. It is presented on `msr_out` while `msr_load`=1.
- R8: The vector address is 0x00000D00 when IP=0 and 0xFFF00D00 when IP=1.
- R9: `redirect` and `msr_load` rise in the cycle after the completion clock edge and last one clock for each entry. The save registers update on that same edge.
- R10: A port write (`rp_wr`=1) stores `rp_wdata` in the register chosen by `rp_sel`. `rp_rdata` shows the register chosen by `rp_sel` one clock later. An entry in the same cycle takes priority over the write.
- R11: After synchronous reset, both save registers read 0, and `redirect` and `msr_load` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_valid | input | 1 | An instruction completed this cycle |
| cmp_next_addr | input | 32 | Address of the instruction after the completed one |
| cmp_is_branch | input | 1 | The completed instruction is a branch |
| cmp_is_rfi | input | 1 | The completed instruction is a return-from-interrupt |
| cmp_faulted | input | 1 | The completed instruction raised another interrupt |
| other_irq | input | 1 | Another interrupt is being taken this cycle |
| msr_in | input | 32 | Current processor state word |
| rp_wr | input | 1 | Register-port write strobe |
| rp_sel | input | 1 | Register select: 0 return address, 1 saved state |
| rp_wdata | input | 32 | Register-port write data |
| rp_rdata | output | 32 | Registered read data |
| redirect | output | 1 | One-clock fetch redirect pulse |
| redirect_addr | output | 32 | Trace vector address |
| msr_load | output | 1 | Load strobe for the new state word |
| msr_out | output | 32 | New state word |

## Verification
Each completion is driven for one cycle on a falling edge. The entry outputs (`redirect`, `redirect_addr`, `msr_load`, `msr_out`) come from a single register stage, so they are sampled on the next falling edge, half a clock after the capturing edge. On the falling edge after that, the bench checks that the pulse has dropped. The save registers are written on that same capturing edge. The port read adds one more register, so a read is driven on a falling edge and checked one full clock later. For the suppressed cases, the bench reads both save registers back and compares them with their prior contents.

// File: rtl/trace_pkg.sv
package trace_pkg;
  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  // state-word field positions, LSB = 0
  localparam int ST_LE  = 0;
  localparam int ST_RI  = 1;
  localparam int ST_IP  = 6;
  localparam int ST_BE  = 9;
  localparam int ST_SE  = 10;
  localparam int ST_ME  = 12;
  localparam int ST_ILE = 16;

  localparam word_t KEEP_MASK = (word_t'(1) << ST_IP) | (word_t'(1) << ST_ME);
endpackage

// File: rtl/trace_detect.sv
module trace_detect (
  input  logic cmp_valid,
  input  logic cmp_is_branch,
  input  logic cmp_is_rfi,
  input  logic cmp_faulted,
  input  logic other_irq,
  input  logic step_en,
  input  logic branch_en,
  output logic fire
);
  logic step_hit;
  logic branch_hit;

  always_comb begin
    step_hit   = step_en & ~cmp_is_rfi;
    branch_hit = branch_en & cmp_is_branch;
    fire       = cmp_valid & ~cmp_faulted & ~other_irq & (step_hit | branch_hit);
  end
endmodule

// File: rtl/trace_save_regs.sv
module trace_save_regs #(
  parameter int W       = 32,
  parameter int STICKY  = 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           fire,
  input  logic [W-1:0]   next_addr,
  input  logic [W/2-1:0] msr_low,
  input  logic           wr_en,
  input  logic           sel,
  input  logic [W-1:0]   wr_data,
  output logic [W-1:0]   rd_data
);
  localparam int HALF = W / 2;

  logic [W-1:0] ret_q;
  logic [W-1:0] st_q;
  logic [W-1:0] st_next;

  always_comb begin
    st_next              = '0;
    st_next[HALF-1:0]    = msr_low;
    st_next[STICKY]      = st_q[STICKY] & msr_low[STICKY];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ret_q   <= '0;
      st_q    <= '0;
      rd_data <= '0;
    end else begin
      if (fire) begin
        ret_q <= next_addr;
        st_q  <= st_next;
      end else if (wr_en) begin
        if (sel) st_q  <= wr_data;
        else     ret_q <= wr_data;
      end
      rd_data <= sel ? st_q : ret_q;
    end
  end

  // R5
  st_upper_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(fire) && !$past(rst) |-> st_q[W-1:HALF] == '0);

  // R6
  sticky_bit_chk: assert property (@(posedge clk) disable iff (rst)
    $past(fire) && !$past(rst) && !$past(msr_low[STICKY]) |-> !st_q[STICKY]);

  // R4
  ret_load_chk: assert property (@(posedge clk) disable iff (rst)
    $past(fire) && !$past(rst) |-> ret_q == $past(next_addr));
endmodule

// File: rtl/trace_entry_unit.sv
module trace_entry_unit #(
  parameter logic [31:0] VEC_OFFSET = 32'h0000_0D00,
  parameter logic [31:0] HI_BASE    = 32'hFFF0_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmp_valid,
  input  logic [31:0] cmp_next_addr,
  input  logic        cmp_is_branch,
  input  logic        cmp_is_rfi,
  input  logic        cmp_faulted,
  input  logic        other_irq,
  input  logic [31:0] msr_in,
  input  logic        rp_wr,
  input  logic        rp_sel,
  input  logic [31:0] rp_wdata,
  output logic [31:0] rp_rdata,
  output logic        redirect,
  output logic [31:0] redirect_addr,
  output logic        msr_load,
  output logic [31:0] msr_out
);
  import trace_pkg::*;

  localparam int HALF = WORD_W / 2;

  logic  fire;
  word_t new_msr;
  word_t vec_addr;

  trace_detect u_detect (
    .cmp_valid     (cmp_valid),
    .cmp_is_branch (cmp_is_branch),
    .cmp_is_rfi    (cmp_is_rfi),
    .cmp_faulted   (cmp_faulted),
    .other_irq     (other_irq),
    .step_en       (msr_in[ST_SE]),
    .branch_en     (msr_in[ST_BE]),
    .fire          (fire)
  );

  trace_save_regs #(.W(WORD_W), .STICKY(ST_RI)) u_save (
    .clk       (clk),
    .rst       (rst),
    .fire      (fire),
    .next_addr (cmp_next_addr),
    .msr_low   (msr_in[HALF-1:0]),
    .wr_en     (rp_wr),
    .sel       (rp_sel),
    .wr_data   (rp_wdata),
    .rd_data   (rp_rdata)
  );

  always_comb begin
    new_msr        = msr_in & KEEP_MASK;
    new_msr[ST_LE] = msr_in[ST_ILE];
    vec_addr       = (msr_in[ST_IP] ? HI_BASE : '0) + VEC_OFFSET;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect      <= 1'b0;
      msr_load      <= 1'b0;
      redirect_addr <= '0;
      msr_out       <= '0;
    end else begin
      redirect <= fire;
      msr_load <= fire;
      if (fire) begin
        redirect_addr <= vec_addr;
        msr_out       <= new_msr;
      end
    end
  end

  // R3
  no_trace_after_fault_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && ($past(cmp_faulted) || $past(other_irq)) |-> !redirect);

  // R8
  vector_offset_chk: assert property (@(posedge clk) disable iff (rst)
    redirect |-> redirect_addr[11:0] == VEC_OFFSET[11:0]);

  // R7
  msr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    msr_load |-> (msr_out & ~(KEEP_MASK | word_t'(1))) == '0);

  // R9
  pulse_cause_chk: assert property (@(posedge clk) disable iff (rst)
    redirect |-> $past(cmp_valid) && msr_load);
endmodule

// File: tb/trace_entry_unit_tb_top.sv
module trace_entry_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmp_valid = 0, cmp_is_branch = 0, cmp_is_rfi = 0, cmp_faulted = 0, other_irq = 0;
  logic [31:0] cmp_next_addr = '0, msr_in = '0;
  logic        rp_wr = 0, rp_sel = 0;
  logic [31:0] rp_wdata = '0;
  logic [31:0] rp_rdata, redirect_addr, msr_out;
  logic        redirect, msr_load;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;  // 50 MHz

  trace_entry_unit dut_i (
    .clk(clk), .rst(rst), .cmp_valid(cmp_valid), .cmp_next_addr(cmp_next_addr),
    .cmp_is_branch(cmp_is_branch), .cmp_is_rfi(cmp_is_rfi), .cmp_faulted(cmp_faulted),
    .other_irq(other_irq), .msr_in(msr_in), .rp_wr(rp_wr), .rp_sel(rp_sel),
    .rp_wdata(rp_wdata), .rp_rdata(rp_rdata), .redirect(redirect),
    .redirect_addr(redirect_addr), .msr_load(msr_load), .msr_out(msr_out)
  );

  localparam logic [31:0] B_LE = 32'h1, B_RI = 32'h2, B_IP = 32'h40, B_BE = 32'h200,
                          B_SE = 32'h400, B_ME = 32'h1000, B_ILE = 32'h1_0000;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_reg(input logic sel, output logic [31:0] val);
    @(negedge clk); rp_sel = sel;
    @(negedge clk); val = rp_rdata;
  endtask

  task automatic write_reg(input logic sel, input logic [31:0] d);
    @(negedge clk); rp_wr = 1; rp_sel = sel; rp_wdata = d;
    @(negedge clk); rp_wr = 0;
  endtask

  // drive one completion; return redirect/addr/msr sampled half a clock after capture
  task automatic complete(input logic [31:0] na, input logic br, input logic rfi,
                          input logic flt, input logic oth, input logic [31:0] msr,
                          output logic rd, output logic [31:0] va, output logic [31:0] mo);
    @(negedge clk);
    cmp_valid = 1; cmp_next_addr = na; cmp_is_branch = br; cmp_is_rfi = rfi;
    cmp_faulted = flt; other_irq = oth; msr_in = msr;
    @(negedge clk);
    cmp_valid = 0; cmp_is_branch = 0; cmp_is_rfi = 0; cmp_faulted = 0; other_irq = 0;
    rd = redirect; va = redirect_addr; mo = msr_out;
  endtask

  function automatic logic [31:0] exp_st(logic [31:0] msr, logic old1);
    logic [31:0] e;
    e = {16'h0, msr[15:0]};
    e[1] = old1 & msr[1];
    return e;
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    check("R11 redirect", {31'b0, redirect}, 32'h0);
    check("R11 msr_load", {31'b0, msr_load}, 32'h0);
    read_reg(0, v); check("R11 ret", v, 32'h0);
    read_reg(1, v); check("R11 st", v, 32'h0);
  endtask

  task automatic t_step();
    logic rd; logic [31:0] va, mo, v, msr;
    msr = B_SE | B_ILE | B_ME | B_RI | 32'hA5A0_0028;
    complete(32'h0000_1234, 0, 0, 0, 0, msr, rd, va, mo);
    check("R1 step fires", {31'b0, rd}, 32'h1);
    check("R8 vec low", va, 32'h0000_0D00);
    check("R7 msr", mo, B_ME | B_LE);
    check("R9 load", {31'b0, msr_load}, 32'h1);
    @(negedge clk);
    check("R9 pulse width", {31'b0, redirect}, 32'h0);
    read_reg(0, v); check("R4 ret", v, 32'h0000_1234);
    read_reg(1, v); check("R5 st", v, exp_st(msr, 1'b0));
  endtask

  task automatic t_rfi();
    logic rd; logic [31:0] va, mo, v;
    complete(32'h0000_5555, 0, 1, 0, 0, B_SE, rd, va, mo);
    check("R1 rfi none", {31'b0, rd}, 32'h0);
    read_reg(0, v); check("R1 ret kept", v, 32'h0000_1234);
  endtask

  task automatic t_branch();
    logic rd; logic [31:0] va, mo, v, msr;
    msr = B_BE | B_IP | B_LE | 32'h8000_0004;
    complete(32'hCAFE_0010, 1, 0, 0, 0, msr, rd, va, mo);
    check("R2 branch fires", {31'b0, rd}, 32'h1);
    check("R8 vec high", va, 32'hFFF0_0D00);
    check("R7 msr ip kept le cleared", mo, B_IP);
    read_reg(0, v); check("R4 ret branch", v, 32'hCAFE_0010);
    complete(32'h0000_7777, 0, 0, 0, 0, B_BE, rd, va, mo);
    check("R2 non-branch none", {31'b0, rd}, 32'h0);
  endtask

  task automatic t_suppress();
    logic rd; logic [31:0] va, mo, v0, v1, a0, a1;
    read_reg(0, v0); read_reg(1, v1);
    complete(32'h1111_0000, 1, 0, 1, 0, B_SE | B_BE | 32'hFF, rd, va, mo);
    check("R3 fault none", {31'b0, rd}, 32'h0);
    complete(32'h2222_0000, 1, 0, 0, 1, B_SE | B_BE | 32'hFF, rd, va, mo);
    check("R3 other irq none", {31'b0, rd}, 32'h0);
    read_reg(0, a0); check("R3 ret kept", a0, v0);
    read_reg(1, a1); check("R3 st kept", a1, v1);
  endtask

  task automatic t_sticky();
    logic rd; logic [31:0] va, mo, v;
    write_reg(1, 32'h0000_0002);
    read_reg(1, v); check("R10 write st", v, 32'h0000_0002);
    complete(32'h40, 0, 0, 0, 0, B_SE | B_RI, rd, va, mo);
    read_reg(1, v); check("R6 stays set", v, exp_st(B_SE | B_RI, 1'b1));
    complete(32'h44, 0, 0, 0, 0, B_SE, rd, va, mo);
    read_reg(1, v); check("R6 cleared by RI=0", v, exp_st(B_SE, 1'b1));
    complete(32'h48, 0, 0, 0, 0, B_SE | B_RI, rd, va, mo);
    read_reg(1, v); check("R6 not set by RI=1", v, exp_st(B_SE | B_RI, 1'b0));
  endtask

  task automatic t_port();
    logic [31:0] v;
    write_reg(0, 32'hDEAD_BEEF);
    read_reg(0, v); check("R10 write ret", v, 32'hDEAD_BEEF);
    // write and trace in the same cycle: trace wins
    @(negedge clk);
    cmp_valid = 1; cmp_next_addr = 32'h0BAD_0000; msr_in = B_SE;
    rp_wr = 1; rp_sel = 0; rp_wdata = 32'h1357_9BDF;
    @(negedge clk);
    cmp_valid = 0; rp_wr = 0;
    check("R9 fires with write", {31'b0, redirect}, 32'h1);
    read_reg(0, v); check("R10 trace priority", v, 32'h0BAD_0000);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_step();
    t_rfi();
    t_branch();
    t_suppress();
    t_sticky();
    t_port();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule